// File: doc/BRIEF.md
# Operand Forwarding Control for a Five-Stage Pipeline

This block chooses where each operand comes from in a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It covers the two ALU inputs in the execute stage and the two inputs of the branch equality comparator in the decode stage. For each of those four inputs it compares the source register field of the consuming instruction with the destination register numbers held in the memory and write-back stages. It then drives both a select code and the selected 32-bit value. The unit is purely combinational and holds no state.

A producer in the memory stage is passed forward only when it is not a load word, because a load's data does not exist until after that stage. The write-back stage feeds only the ALU inputs. A decode-stage branch that needs a write-back value gets it through the register file's write-through. Instructions that write no register carry destination 0, so they can never match. Spacing after loads is left to software no-ops. This block has no stall logic.

Top module: `opfwd_unit`

## Requirements
- R1: The first source field is instruction bits 25:21 and the second source field is bits 20:16. The memory-stage opcode arrives as a separate 6-bit input. No other instruction bits affect any output.
- R2: ALU input A selects the memory-stage ALU result (select code 1) when the execute rs field equals the memory destination, that destination is nonzero, and the memory opcode is not 6'b100011.
- R3: ALU input A selects the write-back result (select code 2) when the execute rs field equals the nonzero write-back destination and R2 does not apply.
- R4: ALU input B follows the rules of R2 and R3, using the execute rt field.
- R5: When the memory and write-back stages both match the same source, the memory-stage value wins.
- R6: With no match, ALU inputs A and B pass the execute operand registers through, and the comparator inputs pass the register-file read data through, all with select code 0.
- R7: Comparator input 1 (using decode rs) and comparator input 2 (using decode rt) select the memory-stage ALU result (code 1) under the same conditions as R2.
- R8: A comparator input never selects the write-back stage. A write-back match alone leaves it at code 0.
- R9: A load word in the memory stage is never a forwarding source. An ALU input then falls back to a matching write-back value or to its register operand.
- R10: A destination of 0 never causes forwarding, even when the source field is also 0.
- R11: No select output ever takes code 3, and each data output equals the input named by its select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_instr | input | 32 | Instruction in the decode stage |
| ex_instr | input | 32 | Instruction in the execute stage |
| mem_op | input | 6 | Opcode of the memory-stage instruction |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| wb_rd | input | 5 | Destination register of the write-back-stage instruction |
| mem_alu | input | 32 | ALU result held in the memory stage |
| wb_result | input | 32 | Result value held in the write-back stage |
| ex_opa | input | 32 | Execute-stage operand A from the pipeline register |
| ex_opb | input | 32 | Execute-stage operand B from the pipeline register |
| id_rdata1 | input | 32 | Register-file read data for decode rs |
| id_rdata2 | input | 32 | Register-file read data for decode rt |
| alu_a | output | 32 | Operand for ALU input A |
| alu_b | output | 32 | Operand for ALU input B |
| cmp_a | output | 32 | Operand for comparator input 1 |
| cmp_b | output | 32 | Operand for comparator input 2 |
| sel_alu_a | output | 2 | Source code for alu_a (0 register, 1 memory, 2 write-back) |
| sel_alu_b | output | 2 | Source code for alu_b |
| sel_cmp_a | output | 2 | Source code for cmp_a |
| sel_cmp_b | output | 2 | Source code for cmp_b |

## Verification
The bench builds the unit with its default 32-bit data width and 5-bit register numbers. At that width, register 31 is the top edge of the compare, and each of the six data inputs can carry its own distinct 32-bit marker. Because every data input carries a different marker, one wrong mux leg shows up at once in the data outputs, separately from the select codes. With 5-bit register numbers, a double match on register 31 and a zero-numbered source against zero destinations are both plain vectors in the table.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

    localparam int INSTR_W  = 32;
    localparam int REG_W    = 5;
    localparam int OP_W     = 6;
    localparam int RS_LSB   = 21;
    localparam int RT_LSB   = 16;

    localparam logic [OP_W-1:0] OP_LOAD_WORD = 6'b100011;

    typedef logic [REG_W-1:0] regnum_t;

    typedef enum logic [1:0] {
        SRC_REG = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } src_sel_e;

    function automatic regnum_t field_rs(input logic [INSTR_W-1:0] ins);
        return ins[RS_LSB +: REG_W];
    endfunction

    function automatic regnum_t field_rt(input logic [INSTR_W-1:0] ins);
        return ins[RT_LSB +: REG_W];
    endfunction

    function automatic logic dest_hits(input regnum_t src, input regnum_t dst);
        return (dst != '0) && (src == dst);
    endfunction

endpackage

// File: rtl/opfwd_pick.sv
module opfwd_pick
    import opfwd_pkg::*;
#(
    parameter bit ALLOW_WB = 1'b1
) (
    input  regnum_t  src,
    input  regnum_t  mem_rd,
    input  logic     mem_ok,
    input  regnum_t  wb_rd,
    output src_sel_e sel
);

    logic mem_hit;
    logic wb_hit;

    assign mem_hit = mem_ok && dest_hits(src, mem_rd);

    generate
        if (ALLOW_WB) begin : g_wb_path
            assign wb_hit = dest_hits(src, wb_rd);
        end else begin : g_no_wb_path
            assign wb_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        if (mem_hit) begin
            sel = SRC_MEM;
        end else if (wb_hit) begin
            sel = SRC_WB;
        end else begin
            sel = SRC_REG;
        end
    end

endmodule

// File: rtl/opfwd_mux.sv
module opfwd_mux
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  src_sel_e          sel,
    input  logic [DATA_W-1:0] reg_v,
    input  logic [DATA_W-1:0] mem_v,
    input  logic [DATA_W-1:0] wb_v,
    output logic [DATA_W-1:0] out_v
);

    always_comb begin
        unique case (sel)
            SRC_MEM: out_v = mem_v;
            SRC_WB:  out_v = wb_v;
            default: out_v = reg_v;
        endcase
    end

endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INSTR_W-1:0] id_instr,
    input  logic [INSTR_W-1:0] ex_instr,
    input  logic [OP_W-1:0]    mem_op,
    input  logic [REG_W-1:0]   mem_rd,
    input  logic [REG_W-1:0]   wb_rd,
    input  logic [DATA_W-1:0]  mem_alu,
    input  logic [DATA_W-1:0]  wb_result,
    input  logic [DATA_W-1:0]  ex_opa,
    input  logic [DATA_W-1:0]  ex_opb,
    input  logic [DATA_W-1:0]  id_rdata1,
    input  logic [DATA_W-1:0]  id_rdata2,
    output logic [DATA_W-1:0]  alu_a,
    output logic [DATA_W-1:0]  alu_b,
    output logic [DATA_W-1:0]  cmp_a,
    output logic [DATA_W-1:0]  cmp_b,
    output logic [1:0]         sel_alu_a,
    output logic [1:0]         sel_alu_b,
    output logic [1:0]         sel_cmp_a,
    output logic [1:0]         sel_cmp_b
);

    // Ports 0,1 feed the ALU (execute stage); ports 2,3 feed the comparator.
    localparam int N_PORTS  = 4;
    localparam int N_ALU    = 2;

    logic                  mem_ok;
    regnum_t               src    [N_PORTS];
    logic [DATA_W-1:0]     reg_v  [N_PORTS];
    logic [DATA_W-1:0]     out_v  [N_PORTS];
    src_sel_e              sel    [N_PORTS];

    assign mem_ok = (mem_op != OP_LOAD_WORD);

    assign src[0] = field_rs(ex_instr);
    assign src[1] = field_rt(ex_instr);
    assign src[2] = field_rs(id_instr);
    assign src[3] = field_rt(id_instr);

    assign reg_v[0] = ex_opa;
    assign reg_v[1] = ex_opb;
    assign reg_v[2] = id_rdata1;
    assign reg_v[3] = id_rdata2;

    generate
        for (genvar p = 0; p < N_PORTS; p++) begin : g_port
            opfwd_pick #(
                .ALLOW_WB (p < N_ALU)
            ) u_pick (
                .src    (src[p]),
                .mem_rd (mem_rd),
                .mem_ok (mem_ok),
                .wb_rd  (wb_rd),
                .sel    (sel[p])
            );

            opfwd_mux #(
                .DATA_W (DATA_W)
            ) u_mux (
                .sel   (sel[p]),
                .reg_v (reg_v[p]),
                .mem_v (mem_alu),
                .wb_v  (wb_result),
                .out_v (out_v[p])
            );
        end
    endgenerate

    assign alu_a     = out_v[0];
    assign alu_b     = out_v[1];
    assign cmp_a     = out_v[2];
    assign cmp_b     = out_v[3];
    assign sel_alu_a = sel[0];
    assign sel_alu_b = sel[1];
    assign sel_cmp_a = sel[2];
    assign sel_cmp_b = sel[3];

endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic [INSTR_W-1:0] id_instr,
    input logic [INSTR_W-1:0] ex_instr,
    input logic [OP_W-1:0]    mem_op,
    input logic [REG_W-1:0]   mem_rd,
    input logic [REG_W-1:0]   wb_rd,
    input logic [DATA_W-1:0]  mem_alu,
    input logic [DATA_W-1:0]  wb_result,
    input logic [DATA_W-1:0]  ex_opa,
    input logic [DATA_W-1:0]  ex_opb,
    input logic [DATA_W-1:0]  id_rdata1,
    input logic [DATA_W-1:0]  id_rdata2,
    input logic [DATA_W-1:0]  alu_a,
    input logic [DATA_W-1:0]  alu_b,
    input logic [DATA_W-1:0]  cmp_a,
    input logic [DATA_W-1:0]  cmp_b,
    input logic [1:0]         sel_alu_a,
    input logic [1:0]         sel_alu_b,
    input logic [1:0]         sel_cmp_a,
    input logic [1:0]         sel_cmp_b
);

    always_comb begin
        // R8
        cmp_no_wb_chk: assert (sel_cmp_a != 2'd2 && sel_cmp_b != 2'd2);
        // R9
        load_no_src_chk: assert (mem_op != OP_LOAD_WORD ||
                                 (sel_alu_a != 2'd1 && sel_alu_b != 2'd1 &&
                                  sel_cmp_a != 2'd1 && sel_cmp_b != 2'd1));
        // R10
        zero_dest_chk: assert ((mem_rd != '0 || (sel_alu_a != 2'd1 && sel_cmp_a != 2'd1)) &&
                               (wb_rd  != '0 || (sel_alu_a != 2'd2 && sel_alu_b != 2'd2)));
        // R11
        sel_code_chk: assert (sel_alu_a != 2'd3 && sel_alu_b != 2'd3 &&
                              sel_cmp_a != 2'd3 && sel_cmp_b != 2'd3);
        // R11
        alu_a_data_chk: assert (sel_alu_a != 2'd0 || alu_a == ex_opa);
        // R11
        mem_data_chk: assert ((sel_alu_b != 2'd1 || alu_b == mem_alu) &&
                              (sel_cmp_a != 2'd1 || cmp_a == mem_alu));
        // R5
        mem_prio_chk: assert (!(mem_op != OP_LOAD_WORD && mem_rd != '0 &&
                                ex_instr[25:21] == mem_rd) || sel_alu_a == 2'd1);
        // R3
        wb_data_chk: assert (sel_alu_a != 2'd2 || alu_a == wb_result);
    end

endmodule

bind opfwd_unit opfwd_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/opfwd_unit_tb.sv
module opfwd_unit_tb;
    import opfwd_pkg::*;

    localparam int DW = 32;

    typedef struct packed {
        logic [4:0] ex_rs;
        logic [4:0] ex_rt;
        logic [4:0] id_rs;
        logic [4:0] id_rt;
        logic [4:0] m_rd;
        logic       m_ld;
        logic [4:0] w_rd;
        logic [1:0] e_a;
        logic [1:0] e_b;
        logic [1:0] e_ca;
        logic [1:0] e_cb;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{5'd3,  5'd1,  5'd0,  5'd0,  5'd3,  1'b0, 5'd0,  2'd1, 2'd0, 2'd0, 2'd0}, // R2
        '{5'd1,  5'd3,  5'd0,  5'd0,  5'd3,  1'b0, 5'd0,  2'd0, 2'd1, 2'd0, 2'd0}, // R4
        '{5'd3,  5'd2,  5'd0,  5'd0,  5'd0,  1'b0, 5'd3,  2'd2, 2'd0, 2'd0, 2'd0}, // R3
        '{5'd1,  5'd3,  5'd0,  5'd0,  5'd5,  1'b0, 5'd3,  2'd0, 2'd2, 2'd0, 2'd0}, // R4
        '{5'd3,  5'd3,  5'd0,  5'd0,  5'd3,  1'b0, 5'd3,  2'd1, 2'd1, 2'd0, 2'd0}, // R5
        '{5'd3,  5'd3,  5'd0,  5'd0,  5'd3,  1'b1, 5'd3,  2'd2, 2'd2, 2'd0, 2'd0}, // R9
        '{5'd3,  5'd4,  5'd0,  5'd0,  5'd3,  1'b1, 5'd0,  2'd0, 2'd0, 2'd0, 2'd0}, // R9
        '{5'd0,  5'd0,  5'd0,  5'd0,  5'd0,  1'b0, 5'd0,  2'd0, 2'd0, 2'd0, 2'd0}, // R10
        '{5'd3,  5'd4,  5'd3,  5'd4,  5'd4,  1'b0, 5'd3,  2'd2, 2'd1, 2'd0, 2'd1}, // R7 R8
        '{5'd5,  5'd6,  5'd4,  5'd7,  5'd4,  1'b0, 5'd7,  2'd0, 2'd0, 2'd1, 2'd0}, // R7 R8
        '{5'd2,  5'd2,  5'd2,  5'd2,  5'd2,  1'b1, 5'd0,  2'd0, 2'd0, 2'd0, 2'd0}, // R9
        '{5'd7,  5'd8,  5'd9,  5'd10, 5'd11, 1'b0, 5'd12, 2'd0, 2'd0, 2'd0, 2'd0}, // R6
        '{5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 1'b0, 5'd31, 2'd1, 2'd1, 2'd1, 2'd1}  // R5 R7
    };

    localparam logic [DW-1:0] V_MEM = 32'hA1A1_0001;
    localparam logic [DW-1:0] V_WB  = 32'hB2B2_0002;
    localparam logic [DW-1:0] V_OPA = 32'hC3C3_0003;
    localparam logic [DW-1:0] V_OPB = 32'hD4D4_0004;
    localparam logic [DW-1:0] V_RD1 = 32'hE5E5_0005;
    localparam logic [DW-1:0] V_RD2 = 32'hF6F6_0006;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [INSTR_W-1:0] id_instr, ex_instr;
    logic [OP_W-1:0]    mem_op;
    logic [REG_W-1:0]   mem_rd, wb_rd;
    logic [DW-1:0]      mem_alu, wb_result, ex_opa, ex_opb, id_rdata1, id_rdata2;
    logic [DW-1:0]      alu_a, alu_b, cmp_a, cmp_b;
    logic [1:0]         sel_alu_a, sel_alu_b, sel_cmp_a, sel_cmp_b;

    opfwd_unit #(.DATA_W(DW)) u_dut (.*);

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always_ff @(posedge clk) cycles <= cycles + 1;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] r);
        return (s == 2'd1) ? V_MEM : (s == 2'd2) ? V_WB : r;
    endfunction

    function automatic logic [INSTR_W-1:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                                input logic [4:0] rt, input logic [15:0] lo);
        return {op, rs, rt, lo};
    endfunction

    task automatic check_all(input string tag, input logic [1:0] ea, input logic [1:0] eb,
                             input logic [1:0] eca, input logic [1:0] ecb);
        chk({tag, " sel_alu_a"}, DW'(sel_alu_a), DW'(ea));
        chk({tag, " sel_alu_b"}, DW'(sel_alu_b), DW'(eb));
        chk({tag, " sel_cmp_a"}, DW'(sel_cmp_a), DW'(eca));
        chk({tag, " sel_cmp_b"}, DW'(sel_cmp_b), DW'(ecb));
        chk({tag, " alu_a"}, alu_a, pick(ea, V_OPA));
        chk({tag, " alu_b"}, alu_b, pick(eb, V_OPB));
        chk({tag, " cmp_a"}, cmp_a, pick(eca, V_RD1));
        chk({tag, " cmp_b"}, cmp_b, pick(ecb, V_RD2));
    endtask

    initial begin
        id_instr = '0; ex_instr = '0; mem_op = '0; mem_rd = '0; wb_rd = '0;
        mem_alu = V_MEM; wb_result = V_WB; ex_opa = V_OPA; ex_opb = V_OPB;
        id_rdata1 = V_RD1; id_rdata2 = V_RD2;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6 R10: idle state after reset, all zero fields
        check_all("R6 reset", 2'd0, 2'd0, 2'd0, 2'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ex_instr = mk(6'b000000, VECS[i].ex_rs, VECS[i].ex_rt, 16'h5A5A);
            id_instr = mk(6'b000100, VECS[i].id_rs, VECS[i].id_rt, 16'hA5A5);
            mem_op   = VECS[i].m_ld ? 6'b100011 : 6'b000000;
            mem_rd   = VECS[i].m_rd;
            wb_rd    = VECS[i].w_rd;
            #1;
            check_all($sformatf("vec %0d", i), VECS[i].e_a, VECS[i].e_b,
                      VECS[i].e_ca, VECS[i].e_cb);
        end

        // R1: non-field bits set, including bits 15:11 equal to the MEM destination
        @(negedge clk);
        ex_instr = mk(6'b111111, 5'd6, 5'd7, 16'hFFFF);
        id_instr = mk(6'b100011, 5'd8, 5'd9, 16'hFFFF);
        mem_op = 6'b000000; mem_rd = 5'd31; wb_rd = 5'd30;
        #1;
        check_all("R1 field", 2'd0, 2'd0, 2'd0, 2'd0);

        // R2 R9: opcode one bit away from load still forwards
        @(negedge clk);
        ex_instr = mk(6'b000000, 5'd12, 5'd13, 16'h0);
        id_instr = mk(6'b000100, 5'd12, 5'd13, 16'h0);
        mem_op = 6'b100010; mem_rd = 5'd12; wb_rd = 5'd13;
        #1;
        check_all("R2 near-load", 2'd1, 2'd2, 2'd1, 2'd0);

        // R9 R8: load in MEM, WB match on comparator stays on register data
        @(negedge clk);
        mem_op = 6'b100011;
        #1;
        check_all("R9 load", 2'd0, 2'd2, 2'd0, 2'd0);

        // R11: data change on selected source propagates
        @(negedge clk);
        mem_op = 6'b000000; wb_result = 32'h1234_5678;
        #1;
        chk("R11 alu_b wb", alu_b, 32'h1234_5678);
        wb_result = V_WB;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cycles >= 10000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule